// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block keeps a set of hardware error-reporting banks, each holding a status word, a faulting address and a word of extra detail, and decides what to do with each newly reported error. An error report arrives as a single-cycle request. The request carries a target bank, a status word, a proposed global status, an address, a detail word and an unconditional flag. In the same cycle the block screens the request against the capability word, the global and per-bank enable masks, the machine-check enable input and the current global status. The outcome is one of six: reject, silent drop, log and raise an interrupt, log quietly, only mark an overflow, or request a system reset.

Configuration arrives on input ports: the capability word, the global control mask, one control mask per bank and the enable. The block itself holds the bank contents and the global status. A combinational read port returns any bank's contents. A nested uncorrected error, meaning one that arrives while a previous one is still being handled, cannot be logged safely. It escalates to a reset request.

Top module: `mcheck_log`

## Requirements
- R1: After reset every bank's status, address and detail word reads zero, the global status reads zero, and done, reject, interrupt and reset-request are low.
- R2: A request is rejected, with no change to any bank or to the global status, in any of three cases: the capability word is zero; the bank index is at or above capability bits [7:0] or at or above NUM_BANKS; or status bit 63 (valid) is clear.
- R3: A request whose status bit 55 (action required) is clear is dropped while global status bit 2 (in progress) is set, unless the unconditional flag is high. A dropped request changes no state.
- R4: A request with status bit 61 (uncorrected) set is dropped in either of two cases: capability bit 8 is set and the global control mask is not all ones; or the target bank's control mask is not all ones.
- R5: An uncorrected request that passes R4 while global status bit 2 is set, or while the enable input is low, produces a reset-request pulse and changes no state.
- R6: Any other uncorrected request writes the address, the detail word, the global status (taken from the request) and the bank status, and raises an interrupt pulse. The stored status is the request status with bit 62 (overflow) also set if the bank already held a valid entry. At most one bank is written per request.
- R7: A corrected request, where bit 61 is clear, overwrites the bank's status, address and detail word when the bank holds no valid entry or holds a corrected one. Bit 62 is set if the bank was valid. No interrupt is raised.
- R8: A corrected request aimed at a bank that holds a valid uncorrected entry only sets bit 62 of the existing status. The address and the detail word are kept.
- R9: Every request yields a done pulse exactly one cycle later. At most one of reject, interrupt and reset-request accompanies it, and none of them appears without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_i | input | 64 | Capability word: [7:0] bank count, bit 8 global mask present |
| gctl_i | input | 64 | Global control mask |
| mce_en_i | input | 1 | Machine-check enable |
| bank_ctl_i | input | 64*NUM_BANKS | Per-bank control masks, bank k at [64k+63:64k] |
| req_i | input | 1 | Request strobe, one cycle per report |
| req_bank_i | input | 8 | Target bank index |
| req_status_i | input | 64 | Reported status word |
| req_gstat_i | input | 64 | Global status to install on an uncorrected log |
| req_addr_i | input | 64 | Faulting address |
| req_misc_i | input | 64 | Extra detail word |
| req_uncond_i | input | 1 | Log even while an error is in progress |
| rd_sel_i | input | BANK_IDX_W | Bank selected on the read port |
| rd_status_o | output | 64 | Selected bank status |
| rd_addr_o | output | 64 | Selected bank address |
| rd_misc_o | output | 64 | Selected bank detail word |
| gstat_o | output | 64 | Global status |
| done_o | output | 1 | Request completed (pulse) |
| reject_o | output | 1 | Request failed validation (pulse) |
| irq_o | output | 1 | Machine-check interrupt (pulse) |
| rst_req_o | output | 1 | System reset request (pulse) |

## Verification
The bench builds the block with NUM_BANKS = 4. It then sets the capability count to 4 or to 2, which brings within reach both ways an index can fail: against the advertised count and against the physical bank count. Four banks let the bench fill one bank and then confirm that a neighbouring bank stays untouched across drops and overflow marks. The in-progress state, used for nested-error escalation and conditional drops, is reached only through an uncorrected log whose global status has bit 2 set. Each scenario therefore starts from a fresh reset.

// File: rtl/mcheck_pkg.sv
package mcheck_pkg;
  localparam int MC_W     = 64;
  localparam int ST_VAL   = 63;
  localparam int ST_OVER  = 62;
  localparam int ST_UC    = 61;
  localparam int ST_AR    = 55;
  localparam int GS_MCIP  = 2;
  localparam int CAP_CTLP = 8;

  typedef enum logic [2:0] {
    ACT_REJECT,
    ACT_DROP,
    ACT_RESET,
    ACT_LOG_UC,
    ACT_LOG_CE,
    ACT_MARK_OVER
  } mc_act_e;

  function automatic logic [MC_W-1:0] with_over(input logic [MC_W-1:0] s, input logic set);
    return set ? (s | (64'd1 << ST_OVER)) : s;
  endfunction

  function automatic logic all_ones(input logic [MC_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/mcheck_screen.sv
module mcheck_screen
  import mcheck_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic [MC_W-1:0] cap_i,
  input  logic [MC_W-1:0] gctl_i,
  input  logic            mce_en_i,
  input  logic            uncond_i,
  input  logic [7:0]      bank_i,
  input  logic [MC_W-1:0] status_i,
  input  logic [MC_W-1:0] gstat_i,
  input  logic [MC_W-1:0] sel_status_i,
  input  logic [MC_W-1:0] sel_ctl_i,
  output mc_act_e         act_o,
  output logic            in_range_o
);
  localparam logic [8:0] NB9 = 9'(NUM_BANKS);

  logic cap_zero, idx_bad, in_prog, is_uc, is_ar, ctl_block;

  always_comb begin
    cap_zero   = (cap_i == '0);
    in_range_o = ({1'b0, bank_i} < NB9);
    idx_bad    = (bank_i >= cap_i[7:0]) || !in_range_o;
    in_prog    = gstat_i[GS_MCIP];
    is_uc      = status_i[ST_UC];
    is_ar      = status_i[ST_AR];
    ctl_block  = (cap_i[CAP_CTLP] && !all_ones(gctl_i)) || !all_ones(sel_ctl_i);

    if (cap_zero || idx_bad || !status_i[ST_VAL])
      act_o = ACT_REJECT;
    else if (!uncond_i && !is_ar && in_prog)
      act_o = ACT_DROP;
    else if (is_uc) begin
      if (ctl_block)
        act_o = ACT_DROP;
      else if (in_prog || !mce_en_i)
        act_o = ACT_RESET;
      else
        act_o = ACT_LOG_UC;
    end
    else if (!sel_status_i[ST_VAL] || !sel_status_i[ST_UC])
      act_o = ACT_LOG_CE;
    else
      act_o = ACT_MARK_OVER;
  end
endmodule

// File: rtl/mcheck_bank.sv
module mcheck_bank
  import mcheck_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_full_i,
  input  logic            wr_over_i,
  input  logic [MC_W-1:0] status_d_i,
  input  logic [MC_W-1:0] addr_d_i,
  input  logic [MC_W-1:0] misc_d_i,
  output logic [MC_W-1:0] status_o,
  output logic [MC_W-1:0] addr_o,
  output logic [MC_W-1:0] misc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      addr_o   <= '0;
      misc_o   <= '0;
    end else if (wr_full_i) begin
      status_o <= status_d_i;
      addr_o   <= addr_d_i;
      misc_o   <= misc_d_i;
    end else if (wr_over_i) begin
      status_o <= with_over(status_o, 1'b1);
    end
  end
endmodule

// File: rtl/mcheck_log.sv
module mcheck_log
  import mcheck_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [63:0]               cap_i,
  input  logic [63:0]               gctl_i,
  input  logic                      mce_en_i,
  input  logic [64*NUM_BANKS-1:0]   bank_ctl_i,
  input  logic                      req_i,
  input  logic [7:0]                req_bank_i,
  input  logic [63:0]               req_status_i,
  input  logic [63:0]               req_gstat_i,
  input  logic [63:0]               req_addr_i,
  input  logic [63:0]               req_misc_i,
  input  logic                      req_uncond_i,
  input  logic [BANK_IDX_W-1:0]     rd_sel_i,
  output logic [63:0]               rd_status_o,
  output logic [63:0]               rd_addr_o,
  output logic [63:0]               rd_misc_o,
  output logic [63:0]               gstat_o,
  output logic                      done_o,
  output logic                      reject_o,
  output logic                      irq_o,
  output logic                      rst_req_o
);
  logic [MC_W-1:0] bk_status [NUM_BANKS];
  logic [MC_W-1:0] bk_addr   [NUM_BANKS];
  logic [MC_W-1:0] bk_misc   [NUM_BANKS];
  logic [MC_W-1:0] gstat_q;

  logic [BANK_IDX_W-1:0] sel;
  logic                  in_range;
  logic [MC_W-1:0]       sel_status, sel_ctl, new_status;
  mc_act_e               act;
  logic                  do_full, do_over;
  logic [NUM_BANKS-1:0]  bank_wr_full, bank_wr_over, bank_wr;

  always_comb begin
    sel        = in_range ? req_bank_i[BANK_IDX_W-1:0] : '0;
    sel_status = bk_status[sel];
    sel_ctl    = bank_ctl_i[64*sel +: 64];
    new_status = with_over(req_status_i, sel_status[ST_VAL]);
    do_full    = req_i && in_range && ((act == ACT_LOG_UC) || (act == ACT_LOG_CE));
    do_over    = req_i && in_range && (act == ACT_MARK_OVER);
  end

  mcheck_screen #(.NUM_BANKS(NUM_BANKS)) u_screen (
    .cap_i        (cap_i),
    .gctl_i       (gctl_i),
    .mce_en_i     (mce_en_i),
    .uncond_i     (req_uncond_i),
    .bank_i       (req_bank_i),
    .status_i     (req_status_i),
    .gstat_i      (gstat_q),
    .sel_status_i (sel_status),
    .sel_ctl_i    (sel_ctl),
    .act_o        (act),
    .in_range_o   (in_range)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    assign bank_wr_full[k] = do_full && (sel == BANK_IDX_W'(k));
    assign bank_wr_over[k] = do_over && (sel == BANK_IDX_W'(k));
    assign bank_wr[k]      = bank_wr_full[k] | bank_wr_over[k];
    mcheck_bank u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_full_i  (bank_wr_full[k]),
      .wr_over_i  (bank_wr_over[k]),
      .status_d_i (new_status),
      .addr_d_i   (req_addr_i),
      .misc_d_i   (req_misc_i),
      .status_o   (bk_status[k]),
      .addr_o     (bk_addr[k]),
      .misc_o     (bk_misc[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gstat_q   <= '0;
      done_o    <= 1'b0;
      reject_o  <= 1'b0;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      done_o    <= req_i;
      reject_o  <= req_i && (act == ACT_REJECT);
      irq_o     <= req_i && (act == ACT_LOG_UC);
      rst_req_o <= req_i && (act == ACT_RESET);
      if (req_i && (act == ACT_LOG_UC))
        gstat_q <= req_gstat_i;
    end
  end

  always_comb begin
    rd_status_o = bk_status[rd_sel_i];
    rd_addr_o   = bk_addr[rd_sel_i];
    rd_misc_o   = bk_misc[rd_sel_i];
    gstat_o     = gstat_q;
  end
endmodule

// File: rtl/mcheck_log_chk.sv
module mcheck_log_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_i,
  input logic                 done_o,
  input logic                 reject_o,
  input logic                 irq_o,
  input logic                 rst_req_o,
  input logic [63:0]          gstat_o,
  input logic [NUM_BANKS-1:0] bank_wr
);
  p_done_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);
  p_no_spurious_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !done_o);
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $onehot0({reject_o, irq_o, rst_req_o}));
  p_outcome_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reject_o || irq_o || rst_req_o) |-> done_o);
  p_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));
  p_reject_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> ($stable(gstat_o) && ($past(bank_wr) == '0)));
  p_reset_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> ($stable(gstat_o) && ($past(bank_wr) == '0)));
endmodule

bind mcheck_log mcheck_log_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .done_o    (done_o),
  .reject_o  (reject_o),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .gstat_o   (gstat_o),
  .bank_wr   (bank_wr)
);

// File: tb/mcheck_log_test.sv
module mcheck_log_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam logic [63:0] VAL  = 64'd1 << 63;
  localparam logic [63:0] OVER = 64'd1 << 62;
  localparam logic [63:0] UC   = 64'd1 << 61;
  localparam logic [63:0] AR   = 64'd1 << 55;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0;
  logic rst_n;
  logic [63:0] cap, gctl;
  logic mce_en;
  logic [64*NB-1:0] bank_ctl;
  logic req, uncond;
  logic [7:0] bank;
  logic [63:0] st, gst, addr, misc;
  logic [1:0] rd_sel;
  logic [63:0] rd_status, rd_addr, rd_misc, gstat;
  logic done, reject, irq, rst_req;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcheck_log #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .gctl_i(gctl), .mce_en_i(mce_en),
    .bank_ctl_i(bank_ctl), .req_i(req), .req_bank_i(bank), .req_status_i(st),
    .req_gstat_i(gst), .req_addr_i(addr), .req_misc_i(misc), .req_uncond_i(uncond),
    .rd_sel_i(rd_sel), .rd_status_o(rd_status), .rd_addr_o(rd_addr), .rd_misc_o(rd_misc),
    .gstat_o(gstat), .done_o(done), .reject_o(reject), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0; uncond = 1'b0; bank = '0;
    st = '0; gst = '0; addr = '0; misc = '0; rd_sel = '0;
    cap = 64'h104; gctl = ONES; mce_en = 1'b1; bank_ctl = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one request; returns outcome {done,reject,irq,rst_req}
  task automatic inject(input logic [7:0] b, input logic [63:0] s, input logic [63:0] g,
                        input logic [63:0] a, input logic [63:0] m, input logic u,
                        output logic [3:0] res);
    bank = b; st = s; gst = g; addr = a; misc = m; uncond = u; req = 1'b1;
    @(negedge clk);
    req = 1'b0; uncond = 1'b0;
    res = {done, reject, irq, rst_req};
    @(negedge clk);
  endtask

  task automatic rd(input int idx);
    rd_sel = 2'(idx);
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flags", {60'd0, done, reject, irq, rst_req}, 64'd0);
    chk("R1 gstat", gstat, 64'd0);
    for (int i = 0; i < NB; i++) begin
      rd(i);
      chk("R1 status", rd_status, 64'd0);
      chk("R1 addr", rd_addr, 64'd0);
      chk("R1 misc", rd_misc, 64'd0);
    end
  endtask

  task automatic t_reject();
    logic [3:0] r;
    do_reset();
    cap = 64'd0;
    inject(8'd0, VAL | 64'h1, 0, 64'hA, 64'hB, 1'b0, r);
    chk("R2 cap zero", 64'(r), 64'b1100);
    cap = 64'h104;
    inject(8'd4, VAL | 64'h1, 0, 64'hA, 64'hB, 1'b0, r);
    chk("R2 idx physical", 64'(r), 64'b1100);
    cap = 64'h102;
    inject(8'd3, VAL | 64'h1, 0, 64'hA, 64'hB, 1'b0, r);
    chk("R2 idx cap", 64'(r), 64'b1100);
    cap = 64'h104;
    inject(8'd1, UC | 64'h1, 64'h4, 64'hA, 64'hB, 1'b0, r);
    chk("R2 not valid", 64'(r), 64'b1100);
    rd(1); chk("R2 bank1 untouched", rd_status, 64'd0);
    rd(3); chk("R2 bank3 untouched", rd_status, 64'd0);
    chk("R2 gstat untouched", gstat, 64'd0);
  endtask

  task automatic t_corrected();
    logic [3:0] r;
    do_reset();
    inject(8'd1, VAL | 64'h11, 64'h4, 64'hA1, 64'hB1, 1'b0, r);
    chk("R7 first ce outcome", 64'(r), 64'b1000);
    rd(1);
    chk("R7 first ce status", rd_status, VAL | 64'h11);
    chk("R7 first ce addr", rd_addr, 64'hA1);
    chk("R7 first ce misc", rd_misc, 64'hB1);
    chk("R7 ce leaves gstat", gstat, 64'd0);
    inject(8'd1, VAL | 64'h22, 0, 64'hA2, 64'hB2, 1'b0, r);
    rd(1);
    chk("R7 second ce status", rd_status, VAL | OVER | 64'h22);
    chk("R7 second ce addr", rd_addr, 64'hA2);
  endtask

  task automatic t_uncorrected_nested();
    logic [3:0] r;
    logic [63:0] ucs;
    do_reset();
    ucs = VAL | UC | AR | 64'h5;
    inject(8'd2, ucs, 64'h5, 64'hC0, 64'hD0, 1'b0, r);
    chk("R6 uc outcome", 64'(r), 64'b1010);
    chk("R6 uc gstat", gstat, 64'h5);
    rd(2);
    chk("R6 uc status", rd_status, ucs);
    chk("R6 uc addr", rd_addr, 64'hC0);
    chk("R6 uc misc", rd_misc, 64'hD0);
    inject(8'd2, VAL | 64'h9, 0, 64'hE0, 64'hF0, 1'b1, r);
    chk("R8 over only outcome", 64'(r), 64'b1000);
    rd(2);
    chk("R8 over only status", rd_status, ucs | OVER);
    chk("R8 addr kept", rd_addr, 64'hC0);
    chk("R8 misc kept", rd_misc, 64'hD0);
    inject(8'd3, VAL | 64'h7, 0, 64'h31, 64'h32, 1'b0, r);
    chk("R3 drop outcome", 64'(r), 64'b1000);
    rd(3); chk("R3 drop bank3", rd_status, 64'd0);
    inject(8'd3, VAL | 64'h7, 0, 64'h31, 64'h32, 1'b1, r);
    rd(3); chk("R3 uncond logs", rd_status, VAL | 64'h7);
    inject(8'd0, VAL | UC | AR | 64'h3, 64'h1, 64'h41, 64'h42, 1'b0, r);
    chk("R5 nested outcome", 64'(r), 64'b1001);
    chk("R5 nested gstat", gstat, 64'h5);
    rd(0); chk("R5 nested bank0", rd_status, 64'd0);
  endtask

  task automatic t_disabled();
    logic [3:0] r;
    do_reset();
    mce_en = 1'b0;
    inject(8'd1, VAL | UC | 64'h2, 64'h1, 64'h51, 64'h52, 1'b0, r);
    chk("R5 disabled outcome", 64'(r), 64'b1001);
    rd(1); chk("R5 disabled bank1", rd_status, 64'd0);
    chk("R5 disabled gstat", gstat, 64'd0);
  endtask

  task automatic t_masks();
    logic [3:0] r;
    do_reset();
    gctl = 64'hFFFF_FFFF_FFFF_FFFE;
    inject(8'd1, VAL | UC | 64'h2, 64'h1, 64'h61, 64'h62, 1'b0, r);
    chk("R4 gctl drop outcome", 64'(r), 64'b1000);
    rd(1); chk("R4 gctl drop bank1", rd_status, 64'd0);
    cap = 64'h004;
    inject(8'd1, VAL | UC | 64'h2, 64'h1, 64'h61, 64'h62, 1'b0, r);
    chk("R4 gctl absent logs", 64'(r), 64'b1010);
    rd(1); chk("R4 gctl absent status", rd_status, VAL | UC | 64'h2);
    bank_ctl[64*0 +: 64] = 64'h7FFF_FFFF_FFFF_FFFF;
    inject(8'd0, VAL | UC | AR | 64'h2, 64'h1, 64'h71, 64'h72, 1'b0, r);
    chk("R4 bank ctl drop outcome", 64'(r), 64'b1000);
    rd(0); chk("R4 bank ctl drop bank0", rd_status, 64'd0);
  endtask

  task automatic t_uc_over();
    logic [3:0] r;
    do_reset();
    inject(8'd0, VAL | 64'h1, 0, 64'h81, 64'h82, 1'b0, r);
    inject(8'd0, VAL | UC | 64'h6, 64'h1, 64'h91, 64'h92, 1'b0, r);
    chk("R6 uc over outcome", 64'(r), 64'b1010);
    rd(0);
    chk("R6 uc over status", rd_status, VAL | UC | OVER | 64'h6);
    chk("R6 uc over addr", rd_addr, 64'h91);
    chk("R9 pulse drops", {60'd0, done, reject, irq, rst_req}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_reject();
    t_corrected();
    t_uncorrected_nested();
    t_disabled();
    t_masks();
    t_uc_over();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule